// File: doc/BRIEF.md
# Heterogeneous Mixed-Scheme Binary Adder

This block adds two unsigned N-bit operands and a carry-in. It returns the N-bit sum and the carry-out. The word is not built with one carry scheme throughout. It is cut into up to three sections that are chained through their carries:

- a carry-lookahead section holds the low-order bits;
- a carry-skip section holds the middle bits;
- a ripple-carry section holds the high-order bits.

The three section widths are elaboration-time parameters. An integrator picks a split that trades speed against switching activity. Whatever split is chosen, the function is always plain modular addition.

A section width of zero removes that section, so single-scheme and two-scheme adders are legal configurations. Elaboration stops with an error in two cases: the three widths do not add up to N, or a section that is present is only one bit wide. Inside the lookahead section, carries are formed in four-bit groups from group generate and propagate terms. Inside the skip section, four-bit blocks let the incoming carry bypass a block whose bits all propagate. In both sections the last group or block may be narrower than four bits. The block is purely combinational.

Top module: `hetero_adder`

## Requirements
- R1: `sum` equals the low N bits of op_a + op_b + carry_in, and `carry_out` equals bit N of that total, for any legal split.
- R2: The lookahead section occupies bits [LA_W-1:0], the skip section the next SK_W bits, and the ripple section the top RC_W bits. A carry leaving any section enters the section above it, so a carry born in a low section reaches the upper bits.
- R3: A section width of 0 removes that section. One-section and two-section splits (for example 0/31/97, 0/126/2, 0/0/64 and 96/0/0) add correctly.
- R4: When every bit of a skip block propagates, the block passes its carry-in straight to its carry-out. Operands of alternating bits (0x55.. plus 0xAA..) with carry_in=1 give sum 0 and carry_out 1.
- R5: The lookahead section works in 4-bit groups. When its width is not a multiple of 4 (for example 30), the final narrower group still produces correct sum bits and carry.
- R6: Total widths of 32, 64, 96 and 128 bits are each supported and add correctly.
- R7: An all-ones operand plus zero with carry_in=1 carries across the whole word, giving sum 0 and carry_out 1. All-ones plus all-ones with carry_in=1 gives sum all-ones and carry_out 1.
- R8: Zero operands with carry_in=0 give sum 0 and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First addend |
| op_b | input | N | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | N | Modular sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench targets the carry hand-offs at section boundaries: operands whose low 32 or 64 bits are all ones, plus one. A design that wired a section's carry-in to the wrong source would drop or duplicate that carry, and the upper bits would come out wrong.

Alternating-bit operands with a carry-in make every skip block take its bypass path. A skip mux with its select inverted would lose the carry partway up the word.

Splits with a 30-bit lookahead section or a 31-bit skip section exercise the narrow final group or block. A design that sized that group as a full four bits would corrupt the top bits of the section or index past them.

Single-section and two-section splits catch a missing bypass of an absent section, which would leave the carry chain floating or stuck.

// File: rtl/hadd_pkg.sv
package hadd_pkg;
   localparam int LA_GROUP   = 4;
   localparam int SKIP_BLOCK = 4;

   // a section is either absent or at least two bits wide
   function automatic bit width_ok(input int w);
      return (w == 0) || (w >= 2);
   endfunction
endpackage

// File: rtl/hadd_la_sec.sv
module hadd_la_sec #(
   parameter int W   = 8,
   parameter int GRP = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);
   localparam int NG = (W + GRP - 1) / GRP;

   logic [NG:0] gc;
   assign gc[0] = cin;
   assign cout  = gc[NG];

   for (genvar gi = 0; gi < NG; gi++) begin : g_grp
      localparam int LO = gi * GRP;
      localparam int GW = (LO + GRP <= W) ? GRP : (W - LO);

      logic [GW-1:0] sg;
      logic          go;

      always_comb begin : p_grp
         logic [GW-1:0] p, g, c;
         logic t, cj, gg, pp, rc;
         p = a[LO +: GW] ^ b[LO +: GW];
         g = a[LO +: GW] & b[LO +: GW];
         // lookahead carry into every bit of the group
         for (int j = 0; j < GW; j++) begin
            t = gc[gi];
            for (int m = 0; m < j; m++) t = t & p[m];
            cj = t;
            for (int k = 0; k < j; k++) begin
               t = g[k];
               for (int m = k + 1; m < j; m++) t = t & p[m];
               cj = cj | t;
            end
            c[j] = cj;
         end
         // group generate / propagate
         gg = 1'b0;
         for (int k = 0; k < GW; k++) begin
            t = g[k];
            for (int m = k + 1; m < GW; m++) t = t & p[m];
            gg = gg | t;
         end
         pp = &p;
         go = gg | (pp & gc[gi]);
         sg = p ^ c;
         // independent rippled carry for cross-checking
         rc = gc[gi];
         for (int j = 0; j < GW; j++) rc = g[j] | (p[j] & rc);
         a_r5_group_carry: assert (go == rc)
            else $error("lookahead group carry disagrees with rippled carry");
      end

      assign s[LO +: GW] = sg;
      assign gc[gi+1]    = go;
   end
endmodule

// File: rtl/hadd_skip_sec.sv
module hadd_skip_sec #(
   parameter int W   = 8,
   parameter int BLK = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);
   localparam int NB = (W + BLK - 1) / BLK;

   logic [NB:0] bc;
   assign bc[0] = cin;
   assign cout  = bc[NB];

   for (genvar bi = 0; bi < NB; bi++) begin : g_blk
      localparam int LO = bi * BLK;
      localparam int BW = (LO + BLK <= W) ? BLK : (W - LO);

      logic [BW-1:0] sm;
      logic          byp;

      always_comb begin : p_blk
         logic [BW-1:0] p, g;
         logic [BW:0]   c;
         p    = a[LO +: BW] ^ b[LO +: BW];
         g    = a[LO +: BW] & b[LO +: BW];
         c[0] = bc[bi];
         for (int j = 0; j < BW; j++) c[j+1] = g[j] | (p[j] & c[j]);
         sm  = p ^ c[BW-1:0];
         byp = (&p) ? bc[bi] : c[BW];
         a_r4_skip_matches_ripple: assert (byp == c[BW])
            else $error("skip carry differs from rippled carry");
         if (&p) begin
            a_r4_propagate_passes: assert (c[BW] == bc[bi])
               else $error("fully propagating block altered its carry");
         end
      end

      assign s[LO +: BW] = sm;
      assign bc[bi+1]    = byp;
   end
endmodule

// File: rtl/hadd_rca_sec.sv
module hadd_rca_sec #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);
   always_comb begin : p_rca
      logic [W:0] c;
      c[0] = cin;
      for (int j = 0; j < W; j++) c[j+1] = (a[j] & b[j]) | ((a[j] ^ b[j]) & c[j]);
      s    = a ^ b ^ c[W-1:0];
      cout = c[W];
      a_r1_ripple_sum: assert ({cout, s} == ((W+1)'(a) + (W+1)'(b) + (W+1)'(cin)))
         else $error("ripple section result is not the arithmetic sum");
   end
endmodule

// File: rtl/hetero_adder.sv
module hetero_adder #(
   parameter int N     = 128,
   parameter int LA_W  = 32,
   parameter int SK_W  = 32,
   parameter int RC_W  = 64,
   parameter int GRP_W = hadd_pkg::LA_GROUP,
   parameter int BLK_W = hadd_pkg::SKIP_BLOCK
) (
   input  logic [N-1:0] op_a,
   input  logic [N-1:0] op_b,
   input  logic         carry_in,
   output logic [N-1:0] sum,
   output logic         carry_out
);
   localparam int SK_LO = LA_W;
   localparam int RC_LO = LA_W + SK_W;

   // elaboration-time legality of the split
   if (LA_W + SK_W + RC_W != N) begin : g_bad_total
      $error("section widths do not add up to N");
   end
   if (!hadd_pkg::width_ok(LA_W) || !hadd_pkg::width_ok(SK_W) || !hadd_pkg::width_ok(RC_W)) begin : g_bad_width
      $error("a present section must be at least two bits wide");
   end
   if (GRP_W < 2 || BLK_W < 2) begin : g_bad_grain
      $error("group and block sizes must be at least two");
   end

   logic c_la, c_sk, c_rc;

   if (LA_W > 0) begin : g_la
      hadd_la_sec #(.W(LA_W), .GRP(GRP_W)) u_la (
         .a(op_a[0 +: LA_W]), .b(op_b[0 +: LA_W]), .cin(carry_in),
         .s(sum[0 +: LA_W]), .cout(c_la));
   end else begin : g_no_la
      assign c_la = carry_in;
   end

   if (SK_W > 0) begin : g_sk
      hadd_skip_sec #(.W(SK_W), .BLK(BLK_W)) u_sk (
         .a(op_a[SK_LO +: SK_W]), .b(op_b[SK_LO +: SK_W]), .cin(c_la),
         .s(sum[SK_LO +: SK_W]), .cout(c_sk));
   end else begin : g_no_sk
      assign c_sk = c_la;
   end

   if (RC_W > 0) begin : g_rc
      hadd_rca_sec #(.W(RC_W)) u_rc (
         .a(op_a[RC_LO +: RC_W]), .b(op_b[RC_LO +: RC_W]), .cin(c_sk),
         .s(sum[RC_LO +: RC_W]), .cout(c_rc));
   end else begin : g_no_rc
      assign c_rc = c_sk;
   end

   assign carry_out = c_rc;
endmodule

// File: tb/test_hetero_adder.sv
module test_hetero_adder;
   localparam int NCFG = 7;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   logic [127:0] a = '0, b = '0;
   logic         ci = 1'b0;

   logic [127:0] s0, s1, s2;
   logic [31:0]  s3;
   logic [63:0]  s4, s6;
   logic [95:0]  s5;
   logic         co0, co1, co2, co3, co4, co5, co6;

   hetero_adder #(.N(128), .LA_W(32), .SK_W(32),  .RC_W(64)) i_hetero_adder (
      .op_a(a), .op_b(b), .carry_in(ci), .sum(s0), .carry_out(co0));
   hetero_adder #(.N(128), .LA_W(0),  .SK_W(31),  .RC_W(97)) i_hetero_adder_b (
      .op_a(a), .op_b(b), .carry_in(ci), .sum(s1), .carry_out(co1));
   hetero_adder #(.N(128), .LA_W(0),  .SK_W(126), .RC_W(2))  i_hetero_adder_c (
      .op_a(a), .op_b(b), .carry_in(ci), .sum(s2), .carry_out(co2));
   hetero_adder #(.N(32),  .LA_W(30), .SK_W(0),   .RC_W(2))  i_hetero_adder_d (
      .op_a(a[31:0]), .op_b(b[31:0]), .carry_in(ci), .sum(s3), .carry_out(co3));
   hetero_adder #(.N(64),  .LA_W(0),  .SK_W(0),   .RC_W(64)) i_hetero_adder_e (
      .op_a(a[63:0]), .op_b(b[63:0]), .carry_in(ci), .sum(s4), .carry_out(co4));
   hetero_adder #(.N(96),  .LA_W(96), .SK_W(0),   .RC_W(0))  i_hetero_adder_f (
      .op_a(a[95:0]), .op_b(b[95:0]), .carry_in(ci), .sum(s5), .carry_out(co5));
   hetero_adder #(.N(64),  .LA_W(10), .SK_W(22),  .RC_W(32)) i_hetero_adder_g (
      .op_a(a[63:0]), .op_b(b[63:0]), .carry_in(ci), .sum(s6), .carry_out(co6));

   logic [128:0] got [NCFG];
   assign got[0] = {co0, s0};
   assign got[1] = {co1, s1};
   assign got[2] = {co2, s2};
   assign got[3] = 129'({co3, s3});
   assign got[4] = 129'({co4, s4});
   assign got[5] = 129'({co5, s5});
   assign got[6] = 129'({co6, s6});

   int cfg_w [NCFG] = '{128, 128, 128, 32, 64, 96, 64};

   typedef struct {
      logic [NCFG-1:0][128:0] exp;
      string                  req;
   } item_t;

   item_t sb [$];
   int checks = 0;
   int fails  = 0;

   function automatic logic [128:0] ref_add(input logic [127:0] x, input logic [127:0] y,
                                            input logic c, input int n);
      logic [128:0] m;
      m = (129'(1) << n) - 129'(1);
      return ({1'b0, x} & m) + ({1'b0, y} & m) + 129'(c);
   endfunction

   task automatic send(input logic [127:0] x, input logic [127:0] y, input logic c, input string req);
      item_t it;
      @(posedge clk);
      a  <= x;
      b  <= y;
      ci <= c;
      for (int k = 0; k < NCFG; k++) it.exp[k] = ref_add(x, y, c, cfg_w[k]);
      it.req = req;
      sb.push_back(it);
   endtask

   // monitor: compares half a cycle after the stimulus
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         for (int k = 0; k < NCFG; k++) begin
            checks++;
            if (got[k] !== it.exp[k]) begin
               fails++;
               $display("FAIL %s cfg%0d got=%h exp=%h", it.req, k, got[k], it.exp[k]);
            end
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else begin
         cyc <= cyc + 1;
         if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      send('0, '0, 1'b0, "R8 zero operands");
      send({128{1'b1}}, '0, 1'b1, "R7 all ones plus carry");
      send({128{1'b1}}, {128{1'b1}}, 1'b1, "R7 all ones twice plus carry");
      send({32{4'h5}}, {32{4'hA}}, 1'b1, "R4 alternating bits full propagate");
      send({32{4'h5}}, {32{4'hA}}, 1'b0, "R4 alternating bits no carry");
      send(128'hFFFF_FFFF, 128'h1, 1'b0, "R2 carry into middle section");
      send({64'h0, {64{1'b1}}}, 128'h1, 1'b0, "R2 carry into top section");
      send(128'h3FFF_FFFF, '0, 1'b1, "R5 partial lookahead group");
      send(128'h1FFF_FFFF, 128'h2000_0000, 1'b1, "R5 carry from partial group");
      send({97'h0, {31{1'b1}}}, '0, 1'b1, "R3 two-section boundary");
      send({2'b01, 126'h0}, {2'b01, 126'h0}, 1'b0, "R3 narrow top ripple");
      for (int i = 0; i < 300; i++)
         send({$urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom},
              1'($urandom), "R1 R3 R6 random");
      repeat (3) @(posedge clk);
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R1 scoreboard not drained got=%0d exp=0", sb.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule